// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Preamble and Break

This block turns bytes written from a processor-side port into asynchronous serial frames on one output line. A single holding register sits in front of an eleven-bit shift register. A bit-rate strobe (`baud_tick`) moves the shifter forward one bit per strobe. Two enables gate the block. The global enable decides whether the block drives the pin at all. The transmit enable starts the shifting engine. Each time the engine is switched on, it first sends one frame length of idle 1s, and only then takes any buffered data.

Software follows the usual flow. It reads the status, sees the buffer-empty flag, and writes the next byte. The empty flag is cleared only by a status read made while the flag is set, followed by a data write. The empty flag can also raise an interrupt request. A second flag reports that the line has gone quiet with nothing left to send. A break control replaces characters with all-zero bit periods. These periods have the length of one character and repeat for as long as the control is held. A stop-level bit always separates the last break from the next start bit.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no character, preamble or break is being shifted, `txd` is 1. After reset `empty_flag` and `done_flag` read 1.
- R2: After `glb_en` and `tx_en` are both high, the first `baud_tick` loads a preamble of 1s that lasts exactly one frame length (10 or 11 bit times). A buffered byte is not sent before the preamble has ended.
- R3: A data frame is sent as a 0 start bit, then the data bits least significant first, then a 1 stop bit. With `long_mode` at 0 the frame has 10 bits. With `long_mode` at 1 it has 11 bits, and the ninth data bit is `wbit_ext` as captured with the write. Each bit lasts one `baud_tick` period.
- R4: `empty_flag` sets in the same clock edge at which the holding register hands its byte to the shifter, and so it is already 1 when the start bit appears. It stays 0 while the written byte is still waiting.
- R5: `empty_flag` clears only when a `data_wr` follows a `stat_rd` that was made while the flag was 1. A `data_wr` without that read leaves the flag at 1, but the byte is still sent.
- R6: `irq` is high exactly when `empty_flag` and `ie_empty` are both high.
- R7: While `brk_req` is 1, the shifter sends break characters of all 0s, each one frame length long (10 or 11 bits), back to back. A pending byte waits until the breaks end.
- R8: When the last break ends, at least one 1 bit is sent before the next start bit.
- R9: With `glb_en` at 0, `txd_oe` is 0 and `txd` is 1. The shifter stops at once, both flags return to 1, and `data_wr` and `stat_rd` have no effect.
- R10: `done_flag` goes to 0 when the shifter loads a frame, preamble or break. It returns to 1 when a shift finishes and nothing follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| glb_en | input | 1 | Global enable, which also drives the pin |
| tx_en | input | 1 | Transmit engine enable |
| long_mode | input | 1 | 0 gives 8 data bits, 1 gives 9 data bits |
| brk_req | input | 1 | Send break characters while high |
| ie_empty | input | 1 | Interrupt enable for the empty flag |
| stat_rd | input | 1 | Status-read strobe |
| data_wr | input | 1 | Data-write strobe |
| wdata | input | 8 | Data byte written with `data_wr` |
| wbit_ext | input | 1 | Ninth data bit written with `data_wr` |
| txd | output | 1 | Serial output line |
| txd_oe | output | 1 | Pin-drive enable |
| empty_flag | output | 1 | Holding register can take a new byte |
| done_flag | output | 1 | Shifter idle with nothing pending |
| irq | output | 1 | Empty-flag interrupt request |

## Verification
The hardest situation to reach is a break that ends while a byte is already waiting in the holding register. To get there, the bench raises `brk_req` first and then writes a byte through the two-step sequence, so the data is parked behind the breaks. It holds the break for about two frame lengths and then releases it at an arbitrary bit position. The captured line must then show a zero run that is a whole number of frames long, a separating 1, and finally the parked byte, while `empty_flag` stays low throughout the break. The preamble count depends on the enable landing at a known distance from a bit strobe, so the bench lines up its enable with the strobe before it counts leading 1s.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // What the shifter currently holds
  typedef enum logic [2:0] {
    K_IDLE = 3'd0,
    K_PRE  = 3'd1,
    K_DATA = 3'd2,
    K_BRK  = 3'd3,
    K_GAP  = 3'd4
  } tx_kind_t;

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              stat_rd,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wbit_ext,
  input  logic              take,
  input  logic              ie_empty,
  output logic              buf_full,
  output logic [DATA_W:0]   buf_word,
  output logic              empty_flag,
  output logic              irq
);

  logic            full_q;
  logic            empty_q;
  logic            armed_q;
  logic [DATA_W:0] word_q;

  // named internal event: a write that completes the two-step clear
  logic clear_evt;
  assign clear_evt = data_wr && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      armed_q <= 1'b0;
      word_q  <= '0;
    end else if (!glb_en) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      // arming: a status read seen while the flag is set
      if (data_wr)
        armed_q <= 1'b0;
      else if (stat_rd && empty_q)
        armed_q <= 1'b1;

      // holding register contents
      if (data_wr) begin
        word_q <= {wbit_ext, wdata};
        full_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end

      // empty flag: a new byte after an armed write wins over a handover
      if (clear_evt)
        empty_q <= 1'b0;
      else if (take)
        empty_q <= 1'b1;
    end
  end

  assign buf_full   = full_q;
  assign buf_word   = word_q;
  assign empty_flag = empty_q;
  assign irq        = empty_q && ie_empty;

  // R5: the flag only drops on a write that follows an armed read
  assert_empty_two_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_q) |-> ($past(data_wr) && $past(armed_q)));

  // R4: the flag rises only on a handover or on global disable
  assert_empty_on_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_q) |-> ($past(take) || !$past(glb_en)));

  // R9: with the block disabled nothing is held
  assert_disabled_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (!full_q && empty_q));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            baud_tick,
  input  logic            long_mode,
  input  logic            brk_req,
  input  logic            buf_full,
  input  logic [DATA_W:0] buf_word,
  output logic            take,
  output logic            txd_bit,
  output logic            done_flag
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // frame length in bit times for the selected character size
  function automatic logic [CNT_W-1:0] frame_len(input logic lng);
    return lng ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
  endfunction

  // start bit at bit 0, data above it, stop level fills the rest
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W:0] w,
                                                    input logic lng);
    logic [FRAME_W-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[DATA_W:1] = w[DATA_W-1:0];
    if (lng) f[DATA_W+1] = w[DATA_W];
    return f;
  endfunction

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  tx_kind_t           kind_q;
  logic               pre_q;
  logic               done_q;

  // named internal events
  logic     bit_end;   // last bit of a unit ends, or the shifter is idle, on a strobe
  logic     shift_evt; // mid-unit advance
  tx_kind_t sel;

  assign bit_end   = active && baud_tick && (cnt_q <= CNT_W'(1));
  assign shift_evt = active && baud_tick && (cnt_q > CNT_W'(1));

  always_comb begin
    sel  = K_IDLE;
    take = 1'b0;
    if (bit_end) begin
      if (pre_q)
        sel = K_PRE;
      else if (brk_req)
        sel = K_BRK;
      else if (kind_q == K_BRK)
        sel = K_GAP;
      else if (buf_full) begin
        sel  = K_DATA;
        take = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      kind_q <= K_IDLE;
      pre_q  <= 1'b1;
      done_q <= 1'b1;
    end else if (!active) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      kind_q <= K_IDLE;
      pre_q  <= 1'b1;
      done_q <= 1'b1;
    end else if (bit_end) begin
      kind_q <= sel;
      case (sel)
        K_PRE: begin
          sh_q  <= '1;
          cnt_q <= frame_len(long_mode);
          pre_q <= 1'b0;
        end
        K_BRK: begin
          sh_q  <= '0;
          cnt_q <= frame_len(long_mode);
        end
        K_GAP: begin
          sh_q  <= '1;
          cnt_q <= CNT_W'(1);
        end
        K_DATA: begin
          sh_q  <= pack_frame(buf_word, long_mode);
          cnt_q <= frame_len(long_mode);
        end
        default: begin
          sh_q  <= '1;
          cnt_q <= '0;
        end
      endcase
      if (sel == K_IDLE) begin
        if (cnt_q != '0) done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end else if (shift_evt) begin
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign txd_bit   = (cnt_q != '0) ? sh_q[0] : 1'b1;
  assign done_flag = done_q;

  // R3: a handed-over byte shows its start bit first
  assert_start_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd_bit);

  // R2: preamble bits are all high
  assert_pre_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_PRE && cnt_q != '0) |-> txd_bit);

  // R2: no data is taken before the preamble has been loaded
  assert_pre_before_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |=> !take);

  // R7: break periods are all low
  assert_brk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_BRK && cnt_q != '0) |-> !txd_bit);

  // R8: the unit after a released break starts at stop level
  assert_gap_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && kind_q == K_BRK && !brk_req && !pre_q) |=> txd_bit);

  // R9: dropping the engine enable idles the line on the next edge
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (txd_bit && done_flag));

  // R3: the counter never exceeds the longest frame
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              glb_en,
  input  logic              tx_en,
  input  logic              long_mode,
  input  logic              brk_req,
  input  logic              ie_empty,
  input  logic              stat_rd,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wbit_ext,
  output logic              txd,
  output logic              txd_oe,
  output logic              empty_flag,
  output logic              done_flag,
  output logic              irq
);

  logic            active;
  logic            take;
  logic            buf_full;
  logic [DATA_W:0] buf_word;
  logic            txd_bit;

  assign active = glb_en && tx_en;

  sertx_holdbuf #(.DATA_W(DATA_W)) u_holdbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_en     (glb_en),
    .stat_rd    (stat_rd),
    .data_wr    (data_wr),
    .wdata      (wdata),
    .wbit_ext   (wbit_ext),
    .take       (take),
    .ie_empty   (ie_empty),
    .buf_full   (buf_full),
    .buf_word   (buf_word),
    .empty_flag (empty_flag),
    .irq        (irq)
  );

  sertx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .baud_tick (baud_tick),
    .long_mode (long_mode),
    .brk_req   (brk_req),
    .buf_full  (buf_full),
    .buf_word  (buf_word),
    .take      (take),
    .txd_bit   (txd_bit),
    .done_flag (done_flag)
  );

  assign txd    = glb_en ? txd_bit : 1'b1;
  assign txd_oe = glb_en;

  // R6: the request only appears with the flag and its enable
  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (empty_flag && ie_empty));

  // R9: a released pin rests high
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (txd && !txd_oe));

  // R9: flags return to their rest values after release
  assert_release_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (empty_flag && done_flag));

endmodule

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       glb_en = 1'b0;
  logic       tx_en = 1'b0;
  logic       long_mode = 1'b0;
  logic       brk_req = 1'b0;
  logic       ie_empty = 1'b0;
  logic       stat_rd = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       wbit_ext = 1'b0;
  logic       txd, txd_oe, empty_flag, done_flag, irq;

  int n_chk = 0;
  int n_err = 0;
  bit fin = 0;
  bit cap_on = 0;
  int div = 0;
  bit stream[$];
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  sertx_top i_sertx_top (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .glb_en(glb_en),
    .tx_en(tx_en), .long_mode(long_mode), .brk_req(brk_req),
    .ie_empty(ie_empty), .stat_rd(stat_rd), .data_wr(data_wr),
    .wdata(wdata), .wbit_ext(wbit_ext), .txd(txd), .txd_oe(txd_oe),
    .empty_flag(empty_flag), .done_flag(done_flag), .irq(irq)
  );

  // bit strobe every 4 clocks; capture the line bit that ends at the next strobe edge
  always @(negedge clk) begin
    if (!rst_n) begin
      div = 0;
      baud_tick = 1'b0;
    end else begin
      div = (div + 1) % 4;
      baud_tick = (div == 3);
      if (cap_on && baud_tick) stream.push_back(txd);
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int flen(input bit lng);
    return lng ? 11 : 10;
  endfunction

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      while (baud_tick !== 1'b1) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic go_enable(input bit lng);
    long_mode = lng;
    @(posedge clk);
    while (baud_tick !== 1'b1) @(posedge clk);
    @(negedge clk);
    stream.delete();
    cap_on = 1;
    glb_en = 1;
    tx_en  = 1;
  endtask

  task automatic disable_all();
    @(negedge clk);
    glb_en = 0;
    tx_en  = 0;
    cap_on = 0;
    brk_req = 0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic b9, input bit two);
    while (empty_flag !== 1'b1) @(negedge clk);
    if (two) begin
      stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
    end
    wdata = b;
    wbit_ext = b9;
    data_wr = 1;
    @(negedge clk);
    data_wr = 0;
    exp_q.push_back({b9, b});
    if (two) chk(empty_flag === 1'b0, "R5 read then write clears empty", empty_flag, 0);
  endtask

  // walk the captured bits from 'start', decode frames, compare to the expected queue
  task automatic decode(input int fl, input int start);
    int i;
    logic [8:0] got;
    logic [8:0] e;
    bit stop;
    i = start;
    while (i < stream.size()) begin
      if (stream[i] == 1'b1) begin
        i++;
      end else if (i + fl > stream.size()) begin
        chk(0, "R3 truncated frame", i, fl);
        i = stream.size();
      end else begin
        got = '0;
        for (int k = 0; k < 8; k++) got[k] = stream[i + 1 + k];
        if (fl == 11) got[8] = stream[i + 9];
        stop = stream[i + fl - 1];
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected frame", int'(got), -1);
        end else begin
          e = exp_q.pop_front();
          if (fl == 10) e[8] = 1'b0;
          chk(got == e, "R3 frame data", int'(got), int'(e));
        end
        chk(stop == 1'b1, "R3 stop bit", stop, 1);
        i += fl;
      end
    end
    chk(exp_q.size() == 0, "R3 all queued frames seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic scen_preamble(input bit lng);
    int fl, ones, bad, guard;
    fl = flen(lng);
    go_enable(lng);
    send_byte(8'($urandom), 1'($urandom), 1);
    bad = 0;
    guard = 0;
    while (txd !== 1'b0 && guard < 4000) begin
      if (empty_flag === 1'b1) bad++;
      @(negedge clk);
      guard++;
    end
    chk(bad == 0, "R4 empty stays low while byte waits", bad, 0);
    chk(empty_flag === 1'b1, "R4 empty set at handover", empty_flag, 1);
    chk(done_flag === 1'b0, "R10 done low while shifting", done_flag, 0);
    wait_ticks(fl + 3);
    chk(done_flag === 1'b1, "R10 done after last frame", done_flag, 1);
    ones = 0;
    while (ones < stream.size() && stream[ones] == 1'b1) ones++;
    chk(ones == fl + 1, "R2 idle sample plus preamble length", ones, fl + 1);
    decode(fl, 0);
    disable_all();
  endtask

  task automatic scen_random(input bit lng, input int n);
    int fl;
    fl = flen(lng);
    go_enable(lng);
    for (int j = 0; j < n; j++) begin
      repeat ($urandom % 20) @(negedge clk);
      ie_empty = 1'($urandom);
      @(negedge clk);
      chk(irq === (empty_flag & ie_empty), "R6 irq gate", irq, empty_flag & ie_empty);
      send_byte(8'($urandom), 1'($urandom), 1);
    end
    while (empty_flag !== 1'b1) @(negedge clk);
    wait_ticks(fl + 3);
    chk(done_flag === 1'b1, "R10 done after burst", done_flag, 1);
    chk(txd === 1'b1, "R1 line rests high", txd, 1);
    decode(fl, 0);
    ie_empty = 0;
    disable_all();
  endtask

  task automatic scen_break(input bit lng, input logic [7:0] b);
    int fl, i, zeros;
    fl = flen(lng);
    go_enable(lng);
    wait_ticks(fl + 3);
    brk_req = 1;
    send_byte(b, 1'b1, 1);
    wait_ticks(2 * fl + 3);
    chk(empty_flag === 1'b0, "R7 byte held behind break", empty_flag, 0);
    brk_req = 0;
    while (empty_flag !== 1'b1) @(negedge clk);
    wait_ticks(fl + 3);
    i = 0;
    while (i < stream.size() && stream[i] == 1'b1) i++;
    zeros = 0;
    while (i < stream.size() && stream[i] == 1'b0) begin
      zeros++;
      i++;
    end
    chk(zeros >= fl && (zeros % fl) == 0, "R7 break run whole characters", zeros, fl);
    chk(i < stream.size() && stream[i] == 1'b1, "R8 stop-level bit after break", i, -1);
    decode(fl, i);
    disable_all();
  endtask

  task automatic scen_noread();
    go_enable(0);
    wait_ticks(12);
    send_byte(8'h3C, 1'b0, 0);
    chk(empty_flag === 1'b1, "R5 write alone leaves empty set", empty_flag, 1);
    wait_ticks(25);
    decode(10, 0);
    disable_all();
  endtask

  task automatic scen_release();
    int zeros, guard;
    go_enable(0);
    send_byte(8'h00, 1'b0, 1);
    guard = 0;
    while (txd !== 1'b0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    repeat (9) @(negedge clk);
    chk(txd === 1'b0, "R3 zero data bit mid frame", txd, 0);
    glb_en = 0;
    cap_on = 0;
    #1;
    chk(txd === 1'b1 && txd_oe === 1'b0, "R9 pin released at once", {txd, txd_oe}, 2);
    @(negedge clk);
    chk(empty_flag === 1'b1 && done_flag === 1'b1, "R9 flags rest after release",
        {empty_flag, done_flag}, 3);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    data_wr = 1;
    wdata = 8'h00;
    @(negedge clk);
    data_wr = 0;
    @(negedge clk);
    chk(empty_flag === 1'b1, "R9 write ignored while disabled", empty_flag, 1);
    tx_en = 0;
    exp_q.delete();
    go_enable(0);
    tx_en = 0;
    @(negedge clk);
    chk(txd_oe === 1'b1 && txd === 1'b1, "R1 engine off pin driven high", {txd_oe, txd}, 3);
    tx_en = 1;
    wait_ticks(40);
    zeros = 0;
    foreach (stream[k]) if (stream[k] == 1'b0) zeros++;
    chk(zeros == 0, "R9 no frame from ignored write", zeros, 0);
    disable_all();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 reset line high", txd, 1);
    chk(txd_oe === 1'b0, "R9 reset pin released", txd_oe, 0);
    chk(empty_flag === 1'b1, "R1 reset empty", empty_flag, 1);
    chk(done_flag === 1'b1, "R1 reset done", done_flag, 1);
    chk(irq === 1'b0, "R6 reset irq with enable low", irq, 0);
    ie_empty = 1;
    @(negedge clk);
    chk(irq === 1'b1, "R6 irq with enable high", irq, 1);
    ie_empty = 0;

    scen_preamble(0);
    scen_preamble(1);
    scen_random(0, 20);
    scen_random(1, 20);
    scen_break(0, 8'hA5);
    scen_break(1, 8'h5A);
    scen_noread();
    scen_release();

    fin = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1: actual %0d expected %0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule